// File: doc/BRIEF.md
# Predicated Branch and Link Evaluator

This block sits in the execute stage of a pipelined processor. It decides whether an instruction may run, and for branches it works out where control goes next. Each instruction word carries a 4-bit predicate in its top nibble. The block tests that predicate against the current negative, zero, carry and overflow flags. The result is an execute-enable that the rest of the execute stage uses.

When the instruction is a branch and its predicate holds, the block raises a taken strobe. It then adds a word-scaled, sign-extended offset to the pipelined PC. That PC already runs two words ahead of the executing instruction. When the link bit is also set, the block raises a write strobe for register index 14. The data on that strobe is the address of the instruction after the branch. The status flags are never saved on the link path.

All outputs are registered, so each result appears one clock after its inputs are presented. Pipeline flushing, register storage and non-branch execution are handled elsewhere.

Top module: `cond_branch_unit`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first edge after it, every output (execute-enable, taken, target, link strobe, link data) is zero, whatever the inputs are.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.
- R3: With flags_i ordered {N,Z,C,V} (bit 3 is N), the predicate codes in instr_i[31:28] are 0000 EQ (Z), 0001 NE (!Z), 0010 CS (C), 0011 CC (!C), 0100 MI (N), 0101 PL (!N), 0110 VS (V) and 0111 VC (!V). exec_en_o is high exactly when the selected test holds.
- R4: The compound codes are 1000 HI (C and !Z), 1001 LS (!C or Z), 1010 GE (N==V), 1011 LT (N!=V), 1100 GT (!Z and N==V) and 1101 LE (Z or N!=V).
- R5: Code 1110 always executes and code 1111 never executes, regardless of the flags.
- R6: An instruction is a branch when instr_i[27:25] is 101. br_taken_o is high only for a branch whose predicate passes.
- R7: On a taken branch, br_target_o is the pipelined PC plus the 24-bit two's-complement field instr_i[23:0], shifted left by two and sign-extended to 32 bits, modulo 2^32. This gives a reach of plus or minus 32 MB.
- R8: link_we_o is high only for a taken branch with instr_i[24] set. link_data_o is then the pipelined PC minus 4, and link_idx_o is 14.
- R9: A failed predicate suppresses both the taken strobe and the link write, even for a branch with the link bit set.
- R10: Non-branch instructions never raise br_taken_o or link_we_o, even when their predicate passes or bit 24 is set.
- R11: br_target_o is zero whenever br_taken_o is low, and link_data_o is zero whenever link_we_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_i | input | 32 | Instruction word in execute |
| pc_i | input | 32 | Pipelined PC, two words ahead of instr_i |
| flags_i | input | 4 | Condition flags {N,Z,C,V} |
| exec_en_o | output | 1 | Predicate passed |
| br_taken_o | output | 1 | Branch taken |
| br_target_o | output | 32 | Branch destination address |
| link_we_o | output | 1 | Link register write strobe |
| link_idx_o | output | 4 | Register index for the link write (14) |
| link_data_o | output | 32 | Return address |

## Verification
Several relations are checked on every cycle. A taken strobe always implies execute-enable, and a link write implies a taken branch with bit 24 set. The link data always equals the previous PC minus four. Code 1110 always runs and code 1111 never does. Non-branch words stay quiet, and the target and link buses are zero when their strobes are low.

Other behaviours can only be shown by the bench's scenarios. These are the exact truth table of each predicate code against chosen flag sets, and the target arithmetic at the offset extremes and across address wraparound. The reset state with a live branch on the inputs is also covered there.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Predicate base tests selected by code[3:1]; code[0] inverts them.
  typedef enum logic [2:0] {
    PB_ZERO   = 3'd0,
    PB_CARRY  = 3'd1,
    PB_NEG    = 3'd2,
    PB_OVF    = 3'd3,
    PB_HIGHER = 3'd4,
    PB_GE     = 3'd5,
    PB_GT     = 3'd6,
    PB_ALWAYS = 3'd7
  } pred_base_e;

  localparam logic [2:0] BRANCH_CLASS = 3'b101;
endpackage

// File: rtl/cbu_decode.sv
module cbu_decode #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 24
) (
  input  logic [XLEN-1:0]  instr,
  output logic [3:0]       pred_code,
  output logic             is_branch,
  output logic             link_bit,
  output logic [OFF_W-1:0] offset
);
  import cbu_pkg::*;

  localparam int CLASS_LSB = OFF_W + 1;

  always_comb begin
    pred_code = instr[XLEN-1 -: 4];
    is_branch = (instr[CLASS_LSB +: 3] == BRANCH_CLASS);
    link_bit  = instr[OFF_W];
    offset    = instr[OFF_W-1:0];
  end
endmodule

// File: rtl/cbu_pred_eval.sv
module cbu_pred_eval (
  input  logic [3:0]      pred_code,
  input  cbu_pkg::flags_t flags,
  output logic            pass
);
  import cbu_pkg::*;

  logic base;
  logic sign_match;

  always_comb begin
    sign_match = (flags.n == flags.v);
    unique case (pred_base_e'(pred_code[3:1]))
      PB_ZERO:   base = flags.z;
      PB_CARRY:  base = flags.c;
      PB_NEG:    base = flags.n;
      PB_OVF:    base = flags.v;
      PB_HIGHER: base = flags.c & ~flags.z;
      PB_GE:     base = sign_match;
      PB_GT:     base = ~flags.z & sign_match;
      PB_ALWAYS: base = 1'b1;
      default:   base = 1'b0;
    endcase
    // Odd codes are the complement of their even partner; 1111 becomes never.
    pass = base ^ pred_code[0];
  end
endmodule

// File: rtl/cbu_branch_calc.sv
module cbu_branch_calc #(
  parameter int XLEN           = 32,
  parameter int OFF_W          = 24,
  parameter int WORD_SHIFT     = 2,
  parameter int PREFETCH_BYTES = 8,
  parameter int INSN_BYTES     = 4
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  ret_addr
);
  localparam int EXT_W = XLEN - OFF_W - WORD_SHIFT;
  localparam logic [XLEN-1:0] BACK_STEP = XLEN'(PREFETCH_BYTES - INSN_BYTES);

  logic [XLEN-1:0] disp;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp = {{EXT_W{offset[OFF_W-1]}}, offset, {WORD_SHIFT{1'b0}}};
    end else begin : g_trunc
      assign disp = XLEN'({offset, {WORD_SHIFT{1'b0}}});
    end
  endgenerate

  assign target   = pc + disp;
  assign ret_addr = pc - BACK_STEP;
endmodule

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 24,
  parameter int LINK_REG = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [3:0]      flags_i,
  output logic            exec_en_o,
  output logic            br_taken_o,
  output logic [XLEN-1:0] br_target_o,
  output logic            link_we_o,
  output logic [3:0]      link_idx_o,
  output logic [XLEN-1:0] link_data_o
);
  import cbu_pkg::*;

  logic [3:0]      pred_code;
  logic            is_branch;
  logic            link_bit;
  logic [OFF_W-1:0] offset;
  logic            pass;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] ret_addr;
  logic            take_nxt;
  logic            link_nxt;

  cbu_decode #(.XLEN(XLEN), .OFF_W(OFF_W)) u_decode (
    .instr     (instr_i),
    .pred_code (pred_code),
    .is_branch (is_branch),
    .link_bit  (link_bit),
    .offset    (offset)
  );

  cbu_pred_eval u_pred (
    .pred_code (pred_code),
    .flags     (flags_t'(flags_i)),
    .pass      (pass)
  );

  cbu_branch_calc #(.XLEN(XLEN), .OFF_W(OFF_W)) u_calc (
    .pc       (pc_i),
    .offset   (offset),
    .target   (target),
    .ret_addr (ret_addr)
  );

  assign take_nxt   = pass & is_branch;
  assign link_nxt   = take_nxt & link_bit;
  assign link_idx_o = 4'(LINK_REG);

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_en_o   <= 1'b0;
      br_taken_o  <= 1'b0;
      br_target_o <= '0;
      link_we_o   <= 1'b0;
      link_data_o <= '0;
    end else begin
      exec_en_o   <= pass;
      br_taken_o  <= take_nxt;
      br_target_o <= take_nxt ? target : '0;
      link_we_o   <= link_nxt;
      link_data_o <= link_nxt ? ret_addr : '0;
    end
  end
endmodule

// File: rtl/cond_branch_unit_chk.sv
module cond_branch_unit_chk #(
  parameter int XLEN  = 32,
  parameter int OFF_W = 24
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] instr_i,
  input logic [XLEN-1:0] pc_i,
  input logic            exec_en_o,
  input logic            br_taken_o,
  input logic [XLEN-1:0] br_target_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_data_o
);
  localparam int CLASS_LSB = OFF_W + 1;

  AST_TAKEN_NEEDS_EXEC: assert property (@(posedge clk) disable iff (rst)
    br_taken_o |-> exec_en_o); // R6

  AST_LINK_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (br_taken_o && $past(instr_i[OFF_W]))); // R8

  AST_LINK_RETURN_ADDR: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (link_data_o == $past(pc_i) - XLEN'(4))); // R8

  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (rst)
    ($past(instr_i[XLEN-1 -: 4]) == 4'hF) |-> !exec_en_o); // R5

  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(instr_i[XLEN-1 -: 4]) == 4'hE) |-> exec_en_o); // R5

  AST_NONBRANCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(instr_i[CLASS_LSB +: 3]) != 3'b101) |-> (!br_taken_o && !link_we_o)); // R10

  AST_TARGET_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !br_taken_o |-> (br_target_o == '0)); // R11

  AST_LINK_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !link_we_o |-> (link_data_o == '0)); // R11
endmodule

bind cond_branch_unit cond_branch_unit_chk #(.XLEN(XLEN), .OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .instr_i     (instr_i),
  .pc_i        (pc_i),
  .exec_en_o   (exec_en_o),
  .br_taken_o  (br_taken_o),
  .br_target_o (br_target_o),
  .link_we_o   (link_we_o),
  .link_data_o (link_data_o)
);

// File: tb/cond_branch_unit_bench.sv
module cond_branch_unit_bench;
  localparam int CLK_NS = 10;
  localparam int NVEC   = 26;
  // entry: {instr[31:0], pc[31:0], flags[3:0] NZCV, exp_exec, exp_taken, exp_link}
  localparam int VW = 71;

  localparam logic [VW-1:0] VEC [NVEC] = '{
    {32'h0A000010, 32'h00001000, 4'b0100, 3'b110}, // EQ Z=1
    {32'h0A000010, 32'h00001000, 4'b0000, 3'b000}, // EQ Z=0
    {32'h1A000010, 32'h00001000, 4'b0000, 3'b110}, // NE
    {32'h2B000020, 32'h00002000, 4'b0010, 3'b111}, // CS with link
    {32'h3A000010, 32'h00001000, 4'b0010, 3'b000}, // CC, C=1
    {32'h4A000010, 32'h00001000, 4'b1000, 3'b110}, // MI
    {32'h5A000010, 32'h00001000, 4'b1000, 3'b000}, // PL, N=1
    {32'h6A000010, 32'h00001000, 4'b0001, 3'b110}, // VS
    {32'h7A000010, 32'h00001000, 4'b0000, 3'b110}, // VC
    {32'h8A000010, 32'h00001000, 4'b0010, 3'b110}, // HI C=1 Z=0
    {32'h8A000010, 32'h00001000, 4'b0110, 3'b000}, // HI C=1 Z=1
    {32'h9A000010, 32'h00001000, 4'b0000, 3'b110}, // LS C=0
    {32'hAA000010, 32'h00001000, 4'b1001, 3'b110}, // GE N=V=1
    {32'hBA000010, 32'h00001000, 4'b1000, 3'b110}, // LT N!=V
    {32'hCA000010, 32'h00001000, 4'b0000, 3'b110}, // GT
    {32'hCA000010, 32'h00001000, 4'b0100, 3'b000}, // GT Z=1
    {32'hDA000010, 32'h00001000, 4'b0001, 3'b110}, // LE N!=V
    {32'hEB000040, 32'h00004000, 4'b0000, 3'b111}, // AL with link
    {32'hFB000040, 32'h00004000, 4'b1111, 3'b000}, // NV with link
    {32'hE0810002, 32'h00001000, 4'b0000, 3'b100}, // non-branch, passes
    {32'hE1A00000, 32'h00001000, 4'b0000, 3'b100}, // non-branch, bit24 set
    {32'hEBFFFFFE, 32'h00001000, 4'b0000, 3'b111}, // offset -2
    {32'hEA7FFFFF, 32'h00000008, 4'b0000, 3'b110}, // max positive offset
    {32'hEA800000, 32'h02000000, 4'b0000, 3'b110}, // most negative offset
    {32'hEB000004, 32'hFFFFFFF0, 4'b0000, 3'b111}, // wraps to zero
    {32'h0B000004, 32'h00001000, 4'b0000, 3'b000}  // failed EQ with link
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_i = '0;
  logic [3:0]  flags_i = '0;
  logic        exec_en_o, br_taken_o, link_we_o;
  logic [31:0] br_target_o, link_data_o;
  logic [3:0]  link_idx_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  cond_branch_unit u_cond_branch_unit (
    .clk(clk), .rst(rst), .instr_i(instr_i), .pc_i(pc_i), .flags_i(flags_i),
    .exec_en_o(exec_en_o), .br_taken_o(br_taken_o), .br_target_o(br_target_o),
    .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_data_o(link_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] calc_target(input logic [31:0] pc, input logic [23:0] off);
    longint signed d;
    d = longint'($signed(off)) * 4;
    return 32'(longint'(pc) + d);
  endfunction

  task automatic apply(input logic [31:0] ins, input logic [31:0] pc, input logic [3:0] fl);
    @(negedge clk);
    instr_i = ins; pc_i = pc; flags_i = fl;
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset with a live link branch on the inputs
    instr_i = 32'hEB000004; pc_i = 32'h00001000; flags_i = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R1 exec", 32'(exec_en_o), 32'd0);
    chk("R1 taken", 32'(br_taken_o), 32'd0);
    chk("R1 target", br_target_o, 32'd0);
    chk("R1 link_we", 32'(link_we_o), 32'd0);
    chk("R1 link_data", link_data_o, 32'd0);
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] ins, pc;
      logic [3:0]  fl;
      logic [2:0]  e;
      {ins, pc, fl, e} = VEC[i];
      apply(ins, pc, fl);
      // R2 one-cycle latency: sampled at the negedge after one posedge
      chk("R2 R3 R4 R5 exec", 32'(exec_en_o), 32'(e[2]));
      chk("R6 R9 R10 taken", 32'(br_taken_o), 32'(e[1]));
      chk("R7 R11 target", br_target_o, e[1] ? calc_target(pc, ins[23:0]) : 32'd0);
      chk("R8 R9 link_we", 32'(link_we_o), 32'(e[0]));
      chk("R8 R11 link_data", link_data_o, e[0] ? pc - 32'd4 : 32'd0);
      chk("R8 link_idx", 32'(link_idx_o), 32'd14);
    end

    // R7 explicit corner values
    apply(32'hEA7FFFFF, 32'h00000008, 4'b0000);
    chk("R7 max reach", br_target_o, 32'h02000004);
    apply(32'hEA800000, 32'h02000000, 4'b0000);
    chk("R7 min reach", br_target_o, 32'h00000000);
    apply(32'hEB000004, 32'hFFFFFFF0, 4'b0000);
    chk("R7 wrap", br_target_o, 32'h00000000);
    chk("R8 wrap link", link_data_o, 32'hFFFFFFEC);

    // R2: output holds previous result until the edge
    @(negedge clk);
    instr_i = 32'hFA000000; flags_i = 4'b1111;
    #1;
    chk("R2 before edge", 32'(br_taken_o), 32'd1);
    @(negedge clk);
    chk("R2 after edge", 32'(br_taken_o), 32'd0);

    // R1: mid-run reset clears outputs
    apply(32'hEB000010, 32'h00003000, 4'b0000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset taken", 32'(br_taken_o), 32'd0);
    chk("R1 mid reset link", link_data_o, 32'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule